// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-visible register file for an Ethernet descriptor DMA engine. A host reaches it over a plain 32-bit word-addressed register bus: a word address, a write strobe, write data and read data that is registered, so a read returns one clock after its address is presented. It holds the bus-mode word, the transmit poll doorbell, the two descriptor ring base addresses, the event status word, the run-control word and the interrupt-enable mask. It also drives one level-sensitive interrupt line.

Toward the transmit and receive descriptor engines it exports a one-cycle transmit poll strobe, both ring base addresses, both current-descriptor pointers and the two run enables. In the other direction it accepts a vector of event pulses that set bits in the status word. When a ring base is programmed, the matching current-descriptor pointer is reloaded at the same time. Software clears status bits by writing ones to them. The interrupt line is raised whenever an enabled status bit is set.

Top module: `edma_csr`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0. `irq`, `tx_poll`, `tx_go` and `rx_go` are 0, and both ring base and both current-descriptor outputs are 0.
- R2: `csr_rdata` shows the register selected by `csr_addr` one clock after the address is sampled. The register's value is taken before any write in that same cycle. Word addresses: bus mode 0x3C0, transmit poll 0x3C1, receive ring base 0x3C3, transmit ring base 0x3C4, status 0x3C5, control 0x3C6, interrupt enable 0x3C7, current transmit descriptor 0x3D2, current receive descriptor 0x3D3, version 0x008.
- R3: The version word always reads 0x00001012, and writes to it have no effect.
- R4: Bus-mode writes store every bit except bit 0 (soft reset), which always reads back 0.
- R5: A write to the transmit poll word raises `tx_poll` for exactly the one cycle after the write edge. The poll word stores nothing and reads 0.
- R6: A write to a ring base word loads the same value into that ring's base and its current-descriptor pointer. The current-descriptor words are read-only from the bus.
- R7: A write to the status word clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R8: Each bit of `evt_set` that is high at an edge sets the matching status bit. A set wins over a same-cycle software clear of that bit. The engines use these bits: transmit done 0, receive done 6, receive buffer unavailable 7, abnormal summary 15, normal summary 16.
- R9: `irq` is high exactly when (status AND interrupt-enable) is non-zero. It follows each write or event from the edge that applies it.
- R10: Control bit 13 drives `tx_go` and control bit 1 drives `rx_go`. Every control bit reads back as written.
- R11: Reads of unmapped words return 0, and writes to unmapped words change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | AW (10) | Word address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | DW (32) | Write data |
| csr_rdata | output | DW (32) | Registered read data |
| evt_set | input | DW (32) | Status set pulses from the engines |
| tx_poll | output | 1 | One-cycle transmit poll strobe |
| tx_go | output | 1 | Transmit run enable |
| rx_go | output | 1 | Receive run enable |
| rx_ring_base | output | DW (32) | Receive ring base address |
| tx_ring_base | output | DW (32) | Transmit ring base address |
| rx_cur_desc | output | DW (32) | Current receive descriptor pointer |
| tx_cur_desc | output | DW (32) | Current transmit descriptor pointer |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted status or enable register shows up on `irq` right after the edge that applies it. It also shows up on `csr_rdata` one clock after that word is read. The bench therefore reads the status word back after every set, clear and set-versus-clear collision, and samples `irq` in the same cycles. A current-descriptor pointer that drifts from its base, or a poll strobe that is stretched, can be seen on the exported engine ports in the cycle after the triggering write. Those ports are sampled in exactly that cycle.

// File: rtl/edma_csr_pkg.sv
package edma_csr_pkg;

    localparam int WORD_AW = 10;
    localparam int CSR_DW  = 32;

    localparam logic [WORD_AW-1:0] WA_VERSION = 10'h008;
    localparam logic [WORD_AW-1:0] WA_BUSMODE = 10'h3C0;
    localparam logic [WORD_AW-1:0] WA_TXPOLL  = 10'h3C1;
    localparam logic [WORD_AW-1:0] WA_RXBASE  = 10'h3C3;
    localparam logic [WORD_AW-1:0] WA_TXBASE  = 10'h3C4;
    localparam logic [WORD_AW-1:0] WA_STATUS  = 10'h3C5;
    localparam logic [WORD_AW-1:0] WA_CTRL    = 10'h3C6;
    localparam logic [WORD_AW-1:0] WA_IEN     = 10'h3C7;
    localparam logic [WORD_AW-1:0] WA_TXCUR   = 10'h3D2;
    localparam logic [WORD_AW-1:0] WA_RXCUR   = 10'h3D3;

    localparam logic [31:0] VERSION_CODE = 32'h0000_1012;

    localparam int BUSMODE_SOFT_RST = 0;
    localparam int CTRL_TX_GO       = 13;
    localparam int CTRL_RX_GO       = 1;

    // status bit positions used by the engines
    localparam int ST_TX_DONE  = 0;
    localparam int ST_RX_DONE  = 6;
    localparam int ST_RX_NOBUF = 7;
    localparam int ST_ABN_SUM  = 15;
    localparam int ST_NRM_SUM  = 16;

    localparam int RING_RX   = 0;
    localparam int RING_TX   = 1;
    localparam int NUM_RINGS = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_VERSION,
        SEL_BUSMODE,
        SEL_TXPOLL,
        SEL_RXBASE,
        SEL_TXBASE,
        SEL_STATUS,
        SEL_CTRL,
        SEL_IEN,
        SEL_TXCUR,
        SEL_RXCUR
    } csr_sel_e;

    typedef struct packed {
        logic                 busmode;
        logic                 poll;
        logic [NUM_RINGS-1:0] base;
        logic                 status;
        logic                 ctrl;
        logic                 ien;
    } csr_we_t;

    function automatic csr_sel_e word_select(input logic [WORD_AW-1:0] w);
        case (w)
            WA_VERSION: return SEL_VERSION;
            WA_BUSMODE: return SEL_BUSMODE;
            WA_TXPOLL:  return SEL_TXPOLL;
            WA_RXBASE:  return SEL_RXBASE;
            WA_TXBASE:  return SEL_TXBASE;
            WA_STATUS:  return SEL_STATUS;
            WA_CTRL:    return SEL_CTRL;
            WA_IEN:     return SEL_IEN;
            WA_TXCUR:   return SEL_TXCUR;
            WA_RXCUR:   return SEL_RXCUR;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/edma_csr_decode.sv
module edma_csr_decode
    import edma_csr_pkg::*;
(
    input  logic               in_range,
    input  logic [WORD_AW-1:0] word,
    input  logic               we,
    output csr_sel_e           sel,
    output csr_we_t            wen
);
    always_comb begin
        sel = in_range ? word_select(word) : SEL_NONE;
        wen = '0;
        wen.busmode       = we && (sel == SEL_BUSMODE);
        wen.poll          = we && (sel == SEL_TXPOLL);
        wen.base[RING_RX] = we && (sel == SEL_RXBASE);
        wen.base[RING_TX] = we && (sel == SEL_TXBASE);
        wen.status        = we && (sel == SEL_STATUS);
        wen.ctrl          = we && (sel == SEL_CTRL);
        wen.ien           = we && (sel == SEL_IEN);
    end
endmodule

// File: rtl/edma_csr_ring.sv
module edma_csr_ring #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] base,
    output logic [DW-1:0] cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            cur  <= '0;
        end else if (load) begin
            base <= load_val;
            cur  <= load_val;
        end
    end

    AST_BASE_LOADS_CUR: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(load_val))); // R6
    AST_CUR_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur)); // R6
endmodule

// File: rtl/edma_csr_status.sv
module edma_csr_status #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_en,
    input  logic [DW-1:0] clr_mask,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] ien,
    output logic [DW-1:0] status,
    output logic          irq
);
    logic [DW-1:0] clr_eff;
    logic [DW-1:0] status_nx;

    always_comb begin
        clr_eff   = clr_en ? clr_mask : '0;
        status_nx = (status & ~clr_eff) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_nx;
    end

    assign irq = |(status & ien);

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_en && set_vec == '0) |=> (status == ($past(status) & ~$past(clr_mask)))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R8
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(|set_vec) || !$stable(ien))); // R9
endmodule

// File: rtl/edma_csr.sv
module edma_csr
    import edma_csr_pkg::*;
#(
    parameter int AW = WORD_AW,
    parameter int DW = CSR_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] csr_addr,
    input  logic          csr_we,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    input  logic [DW-1:0] evt_set,
    output logic          tx_poll,
    output logic          tx_go,
    output logic          rx_go,
    output logic [DW-1:0] rx_ring_base,
    output logic [DW-1:0] tx_ring_base,
    output logic [DW-1:0] rx_cur_desc,
    output logic [DW-1:0] tx_cur_desc,
    output logic          irq
);
    localparam logic [DW-1:0] BUSMODE_KEEP = ~(DW'(1) << BUSMODE_SOFT_RST);

    logic          in_range;
    csr_sel_e      sel;
    csr_we_t       wen;
    logic [DW-1:0] busmode_q;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] ien_q;
    logic [DW-1:0] status_q;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] ring_base [NUM_RINGS];
    logic [DW-1:0] ring_cur  [NUM_RINGS];

    assign in_range = (csr_addr >> WORD_AW) == '0; // R11

    edma_csr_decode u_decode (
        .in_range (in_range),
        .word     (csr_addr[WORD_AW-1:0]),
        .we       (csr_we),
        .sel      (sel),
        .wen      (wen)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        edma_csr_ring #(.DW(DW)) u_ring (
            .clk      (clk),
            .rst      (rst),
            .load     (wen.base[g]),
            .load_val (csr_wdata),
            .base     (ring_base[g]),
            .cur      (ring_cur[g])
        );
    end

    edma_csr_status #(.DW(DW)) u_status (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (wen.status),
        .clr_mask (csr_wdata),
        .set_vec  (evt_set),
        .ien      (ien_q),
        .status   (status_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busmode_q <= '0;
            ctrl_q    <= '0;
            ien_q     <= '0;
            tx_poll   <= 1'b0;
        end else begin
            if (wen.busmode) busmode_q <= csr_wdata & BUSMODE_KEEP; // R4
            if (wen.ctrl)    ctrl_q    <= csr_wdata;
            if (wen.ien)     ien_q     <= csr_wdata;
            tx_poll <= wen.poll; // R5
        end
    end

    always_comb begin
        case (sel)
            SEL_VERSION: rd_val = DW'(VERSION_CODE);
            SEL_BUSMODE: rd_val = busmode_q;
            SEL_RXBASE:  rd_val = ring_base[RING_RX];
            SEL_TXBASE:  rd_val = ring_base[RING_TX];
            SEL_STATUS:  rd_val = status_q;
            SEL_CTRL:    rd_val = ctrl_q;
            SEL_IEN:     rd_val = ien_q;
            SEL_TXCUR:   rd_val = ring_cur[RING_TX];
            SEL_RXCUR:   rd_val = ring_cur[RING_RX];
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) csr_rdata <= '0;
        else     csr_rdata <= rd_val;
    end

    assign tx_go        = ctrl_q[CTRL_TX_GO];
    assign rx_go        = ctrl_q[CTRL_RX_GO];
    assign rx_ring_base = ring_base[RING_RX];
    assign tx_ring_base = ring_base[RING_TX];
    assign rx_cur_desc  = ring_cur[RING_RX];
    assign tx_cur_desc  = ring_cur[RING_TX];

    AST_POLL_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        tx_poll |-> $past(wen.poll)); // R5
    AST_BUSMODE_RST_LOW: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_BUSMODE) |=> !csr_rdata[BUSMODE_SOFT_RST]); // R4
    AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_VERSION) |=> (csr_rdata == DW'(VERSION_CODE))); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |=> (csr_rdata == '0)); // R11
endmodule

// File: tb/edma_csr_bench.sv
`timescale 1ns/1ps
module edma_csr_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] evt_set = '0;
    logic        tx_poll, tx_go, rx_go, irq;
    logic [31:0] rx_ring_base, tx_ring_base, rx_cur_desc, tx_cur_desc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t pend[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edma_csr u_edma_csr (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .evt_set(evt_set),
        .tx_poll(tx_poll), .tx_go(tx_go), .rx_go(rx_go),
        .rx_ring_base(rx_ring_base), .tx_ring_base(tx_ring_base),
        .rx_cur_desc(rx_cur_desc), .tx_cur_desc(tx_cur_desc), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data in the cycle it is due
    always @(negedge clk) begin
        while (pend.size() > 0 && pend[0].due == cyc) begin
            rd_item_t it;
            it = pend.pop_front();
            chk(it.tag, csr_rdata, it.exp);
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [31:0] s = '0);
        csr_addr = a; csr_we = 1'b1; csr_wdata = d; evt_set = s;
        @(negedge clk);
        csr_we = 1'b0; evt_set = '0;
    endtask

    task automatic pulse(input logic [31:0] s);
        evt_set = s;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        csr_addr = a; csr_we = 1'b0;
        it.due = cyc + 1; it.exp = exp; it.tag = tag;
        pend.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 tx_poll", {31'd0, tx_poll}, 0);
        chk("R1 go", {30'd0, tx_go, rx_go}, 0);
        chk("R1 cur", rx_cur_desc | tx_cur_desc | rx_ring_base | tx_ring_base, 0);
        rd(10'h3C5, 0, "R1 status");
        rd(10'h3C6, 0, "R1 ctrl");
        rd(10'h3C0, 0, "R1 busmode");
        // R3 version
        rd(10'h008, 32'h1012, "R3 version");
        wr(10'h008, 32'hFFFF_FFFF);
        rd(10'h008, 32'h1012, "R3 version after write");
        // R4 bus mode
        wr(10'h3C0, 32'hA5A5_0F0F);
        rd(10'h3C0, 32'hA5A5_0F0E, "R4 busmode");
        // R5 poll
        wr(10'h3C1, 32'h1);
        chk("R5 poll high", {31'd0, tx_poll}, 1);
        @(negedge clk);
        chk("R5 poll low", {31'd0, tx_poll}, 0);
        rd(10'h3C1, 0, "R5 poll reads 0");
        // R6 rings
        wr(10'h3C3, 32'h1000_0040);
        chk("R6 rx base out", rx_ring_base, 32'h1000_0040);
        chk("R6 rx cur out", rx_cur_desc, 32'h1000_0040);
        wr(10'h3C4, 32'h2000_0080);
        chk("R6 tx cur out", tx_cur_desc, 32'h2000_0080);
        wr(10'h3D2, 32'h0000_DEAD);
        rd(10'h3D2, 32'h2000_0080, "R6 tx cur read-only");
        rd(10'h3D3, 32'h1000_0040, "R6 rx cur read");
        rd(10'h3C4, 32'h2000_0080, "R2 tx base read");
        // R10 control
        wr(10'h3C6, 32'h0000_2000);
        chk("R10 tx only", {30'd0, tx_go, rx_go}, 32'h2);
        wr(10'h3C6, 32'h8000_2002);
        chk("R10 both", {30'd0, tx_go, rx_go}, 32'h3);
        rd(10'h3C6, 32'h8000_2002, "R10 ctrl readback");
        wr(10'h3C6, 32'h0000_0002);
        chk("R10 rx only", {30'd0, tx_go, rx_go}, 32'h1);
        // R8 set, R9 irq
        pulse(32'h0001_0001);
        chk("R9 irq masked", {31'd0, irq}, 0);
        rd(10'h3C5, 32'h0001_0001, "R8 set bits");
        wr(10'h3C7, 32'h0001_0000);
        chk("R9 irq enabled", {31'd0, irq}, 1);
        // R7 W1C
        wr(10'h3C5, 32'h0000_0001);
        rd(10'h3C5, 32'h0001_0000, "R7 partial clear");
        chk("R9 irq still", {31'd0, irq}, 1);
        wr(10'h3C5, 32'h0001_0000);
        chk("R9 irq cleared", {31'd0, irq}, 0);
        rd(10'h3C5, 0, "R7 all clear");
        // R8 set beats clear
        pulse(32'h0000_0040);
        wr(10'h3C5, 32'h0000_00C0, 32'h0000_0080);
        rd(10'h3C5, 32'h0000_0080, "R8 set wins");
        chk("R9 irq off", {31'd0, irq}, 0);
        wr(10'h3C7, 32'h0000_0080);
        chk("R9 irq on enable", {31'd0, irq}, 1);
        wr(10'h3C7, 32'h0000_0000);
        chk("R9 irq off mask", {31'd0, irq}, 0);
        // R11 unmapped
        wr(10'h3C2, 32'h1234_5678);
        rd(10'h3C2, 0, "R11 unmapped read");
        wr(10'h3FF, 32'hFFFF_FFFF);
        rd(10'h3C6, 32'h0000_0002, "R11 ctrl untouched");
        rd(10'h3C5, 32'h0000_0080, "R11 status untouched");
        rd(10'h100, 0, "R11 unmapped low");
        repeat (3) @(negedge clk);
        chk("R2 reads drained", pend.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule